// File: doc/BRIEF.md
# Single-Wire Register Write Receiver

This block takes register writes from a host that drives one wire, which sits high when idle. A local clock oversamples the wire. The block needs no fixed bit rate. At the front of every frame the host sends two low-then-high pulse pairs. The first pair only wakes the receiver. The block measures the second pair to learn the bit period in sampling clocks. A low start bit comes next, then a 5-bit register address and an 8-bit data value. Both fields are sent most significant bit first.

A write counts only after the host has held the wire high for five bit periods following the last data bit. When that happens, the block drives the address and data onto its outputs and pulses a one-cycle write strobe. A 32-entry register file outside the block consumes the strobe.

The wire passes through a two-flop synchronizer and a 2-of-3 majority filter before edge detection. A frame fails when the measured period falls outside the configured range or when the start bit is not low. A failed frame raises a one-cycle error pulse. A frame whose standby interval is cut short is dropped without an error. The block ignores the wire whenever the oscillator-ready input is low.

Top module: `wire_reg_rx`

## Requirements
- R1: After reset, wrStrobe, frameErr and busy are 0, and wrAddr and wrData are all zeros.
- R2: A valid frame produces exactly one single-cycle wrStrobe. At that strobe, wrAddr carries the 5 address bits and wrData carries the 8 data bits, each taken most significant bit first in wire order. Both outputs hold their values until the next strobe.
- R3: The bit period equals half the number of sampling clocks between the falling edge that opens the calibration pair and the falling edge of the start bit. The durations of the wake pair have no effect on decoding.
- R4: If the measured period is below MIN_PER or above MAX_PER sampling clocks, the frame is discarded and frameErr pulses for one cycle with no strobe. Periods of exactly MIN_PER and MAX_PER are accepted.
- R5: If the start bit reads high at its mid-point, the frame is discarded and frameErr pulses for one cycle with no strobe.
- R6: wrStrobe never rises before the wire has been high for five measured bit periods after the end of the last data bit.
- R7: If the wire goes low during the standby interval, the write is dropped. No strobe and no error follow, wrAddr and wrData keep their previous values, and busy returns to 0.
- R8: While oscReady is low, the receiver stays idle (busy is 0 from the next cycle on), and frames produce neither a strobe nor an error.
- R9: A low glitch one sampling clock wide is filtered out. It does not start a frame while idle, and it does not corrupt a bit inside a frame.
- R10: busy is 1 from shortly after the first falling edge of a frame until the frame ends. The frame ends on the strobe, an error or a drop. busy is 0 in the cycle in which wrStrobe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw serial wire from the host, idle high |
| oscReady | input | 1 | High when the sampling oscillator is usable; low forces idle |
| wrAddr | output | 5 | Register address of the last completed write |
| wrData | output | 8 | Data of the last completed write |
| wrStrobe | output | 1 | One-cycle pulse when a write completes |
| frameErr | output | 1 | One-cycle pulse when a frame is rejected |
| busy | output | 1 | High while a frame is being received |

## Verification
The bench builds the receiver with MIN_PER = 20 and MAX_PER = 60. With these values, frames one clock inside and one clock outside both ends of the accepted period range stay short. Periods of 19, 20, 33, 40, 60 and 61 clocks are sent, and the odd value 33 exercises the rounding of the mid-bit sample point. The narrow range also keeps the standby gate of five periods short enough that the early-strobe window, the broken-standby drop and the stretched wake pair each fit into a few hundred cycles.

// File: rtl/wrx_pkg.sv
package wrx_pkg;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int STBY_BITS  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE_LO, ST_WAKE_HI, ST_CAL_LO,
    ST_CAL_HI, ST_BITS, ST_TAIL, ST_STANDBY
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic calClr;
    logic perLoad;
    logic bitClr;
    logic sampleTake;
    logic stbClr;
    logic commit;
    logic err;
  } rxCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic rise;
    logic fall;
    logic lineF;
    logic calOver;
    logic perBad;
    logic atHalf;
    logic atEnd;
    logic firstBit;
    logic lastBit;
    logic stbDone;
  } rxStat_t;

endpackage

// File: rtl/wrx_datapath.sv
module wrx_datapath
  import wrx_pkg::*;
#(
  parameter int MIN_PER = 20,
  parameter int MAX_PER = 250
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineIn,
  input  rxCtl_t              ctl,
  output rxStat_t             stat,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                wrStrobe,
  output logic                frameErr
);

  localparam int CAL_LIM = 2 * MAX_PER + 2;
  localparam int CW      = $clog2(CAL_LIM + 1);
  localparam int PW      = $clog2(MAX_PER + 1);
  localparam int SW      = $clog2(STBY_BITS * MAX_PER + 1);
  localparam int IW      = $clog2(FRAME_BITS + 1);
  localparam int FILT_N  = 3;

  // input conditioning
  logic [1:0]        syncQ;
  logic [FILT_N-1:0] filtQ;
  logic              lineF, lineD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      filtQ <= '1;
      lineF <= 1'b1;
      lineD <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      filtQ <= {filtQ[FILT_N-2:0], syncQ[1]};
      lineF <= (filtQ[0] & filtQ[1]) | (filtQ[0] & filtQ[2]) | (filtQ[1] & filtQ[2]);
      lineD <= lineF;
    end
  end

  logic rise, fall;
  assign rise = lineF & ~lineD;
  assign fall = ~lineF & lineD;

  // calibration counter and period
  logic [CW-1:0] calCnt;
  logic [CW:0]   meas;
  logic [PW-1:0] period;

  always_ff @(posedge clk) begin
    if (!rstN)                     calCnt <= '0;
    else if (ctl.calClr)           calCnt <= '0;
    else if (calCnt != CW'(CAL_LIM)) calCnt <= calCnt + 1'b1;
  end

  assign meas = ({1'b0, calCnt} + 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN)            period <= '0;
    else if (ctl.perLoad) period <= meas[PW-1:0];
  end

  // bit phase, re-aligned on every filtered edge
  logic [PW-1:0] phase;
  logic          atEnd;
  assign atEnd = (phase == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                              phase <= '0;
    else if (ctl.bitClr || rise || fall || atEnd) phase <= '0;
    else                                    phase <= phase + 1'b1;
  end

  // bit index and shift register
  logic [IW-1:0]         bitIdx;
  logic [FRAME_BITS-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
      shiftQ <= '0;
    end else if (ctl.bitClr) begin
      bitIdx <= '0;
    end else if (ctl.sampleTake) begin
      bitIdx <= bitIdx + 1'b1;
      shiftQ <= {shiftQ[FRAME_BITS-2:0], lineF};
    end
  end

  // standby counter
  logic [SW-1:0] stbCnt;
  logic [SW-1:0] stbLim;
  assign stbLim = SW'(period) + (SW'(period) << 2);

  always_ff @(posedge clk) begin
    if (!rstN)           stbCnt <= '0;
    else if (ctl.stbClr) stbCnt <= '0;
    else                 stbCnt <= stbCnt + 1'b1;
  end

  // output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr   <= '0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      wrStrobe <= ctl.commit;
      frameErr <= ctl.err;
      if (ctl.commit) begin
        wrAddr <= shiftQ[FRAME_BITS-1:DATA_W];
        wrData <= shiftQ[DATA_W-1:0];
      end
    end
  end

  always_comb begin
    stat          = '0;
    stat.rise     = rise;
    stat.fall     = fall;
    stat.lineF    = lineF;
    stat.calOver  = (calCnt == CW'(CAL_LIM));
    stat.perBad   = (meas < (CW+1)'(MIN_PER)) || (meas > (CW+1)'(MAX_PER));
    stat.atHalf   = (phase == (period >> 1));
    stat.atEnd    = atEnd;
    stat.firstBit = (bitIdx == '0);
    stat.lastBit  = (bitIdx == IW'(FRAME_BITS));
    stat.stbDone  = (stbCnt == stbLim - 1'b1);
  end

endmodule

// File: rtl/wrx_ctrl.sv
module wrx_ctrl
  import wrx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    oscReady,
  input  rxStat_t stat,
  output rxCtl_t  ctl,
  output logic    busy
);

  rxState_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    unique case (st)
      ST_IDLE:    if (stat.fall) nxt = ST_WAKE_LO;
      ST_WAKE_LO: if (stat.rise) nxt = ST_WAKE_HI;
      ST_WAKE_HI: if (stat.fall) begin
                    nxt        = ST_CAL_LO;
                    ctl.calClr = 1'b1;
                  end
      ST_CAL_LO:  if (stat.calOver) begin
                    ctl.err = 1'b1;
                    nxt     = ST_IDLE;
                  end else if (stat.rise) begin
                    nxt = ST_CAL_HI;
                  end
      ST_CAL_HI:  if (stat.calOver) begin
                    ctl.err = 1'b1;
                    nxt     = ST_IDLE;
                  end else if (stat.fall) begin
                    if (stat.perBad) begin
                      ctl.err = 1'b1;
                      nxt     = ST_IDLE;
                    end else begin
                      ctl.perLoad = 1'b1;
                      ctl.bitClr  = 1'b1;
                      nxt         = ST_BITS;
                    end
                  end
      ST_BITS:    if (stat.atHalf) begin
                    if (stat.firstBit && stat.lineF) begin
                      ctl.err = 1'b1;
                      nxt     = ST_IDLE;
                    end else begin
                      ctl.sampleTake = 1'b1;
                      if (stat.lastBit) nxt = ST_TAIL;
                    end
                  end
      ST_TAIL:    if (stat.rise || (stat.atEnd && stat.lineF)) begin
                    ctl.stbClr = 1'b1;
                    nxt        = ST_STANDBY;
                  end
      ST_STANDBY: if (!stat.lineF) begin
                    nxt = ST_IDLE;
                  end else if (stat.stbDone) begin
                    ctl.commit = 1'b1;
                    nxt        = ST_IDLE;
                  end
      default:    nxt = ST_IDLE;
    endcase
    if (!oscReady) begin
      nxt = ST_IDLE;
      ctl = '0;
    end
  end

  assign busy = (st != ST_IDLE);

endmodule

// File: rtl/wire_reg_rx.sv
module wire_reg_rx
  import wrx_pkg::*;
#(
  parameter int MIN_PER = 20,
  parameter int MAX_PER = 250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              oscReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStrobe,
  output logic              frameErr,
  output logic              busy
);

  rxCtl_t  ctl;
  rxStat_t stat;

  wrx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .oscReady (oscReady),
    .stat     (stat),
    .ctl      (ctl),
    .busy     (busy)
  );

  wrx_datapath #(
    .MIN_PER (MIN_PER),
    .MAX_PER (MAX_PER)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .ctl      (ctl),
    .stat     (stat),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrStrobe (wrStrobe),
    .frameErr (frameErr)
  );

endmodule

// File: rtl/wrx_chk.sv
module wrx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscReady,
  input logic [4:0] wrAddr,
  input logic [7:0] wrData,
  input logic       wrStrobe,
  input logic       frameErr,
  input logic       busy
);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R10
  strobe_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (!busy && $past(busy)));

  // R4
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (!wrStrobe && !busy));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> ($stable(wrAddr) && $stable(wrData)));

  // R8
  osc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!oscReady) |-> !busy);

endmodule

bind wire_reg_rx wrx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .oscReady (oscReady),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .wrStrobe (wrStrobe),
  .frameErr (frameErr),
  .busy     (busy)
);

// File: tb/wire_reg_rx_tb.sv
module wire_reg_rx_tb;

  localparam int MINP = 20;
  localparam int MAXP = 60;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineIn = 1'b1;
  logic       oscReady = 1'b1;
  logic [4:0] wrAddr;
  logic [7:0] wrData;
  logic       wrStrobe, frameErr, busy;

  always #10 clk = ~clk;

  wire_reg_rx #(.MIN_PER(MINP), .MAX_PER(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .oscReady(oscReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrobe(wrStrobe),
    .frameErr(frameErr), .busy(busy)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  bit allowWrite = 0;

  // reference model: expected events (1 = write, 2 = error)
  int          expKind[$];
  logic [12:0] expVal[$];
  string       expReq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (wrStrobe) begin
        if (expKind.size() == 0 || expKind[0] != 1) begin
          check(0, "R2", "unexpected write strobe", 1, 0);
        end else begin
          check(allowWrite, "R6", "strobe before standby elapsed", 0, 1);
          check({wrAddr, wrData} == expVal[0], expReq[0], "address/data",
                int'({wrAddr, wrData}), int'(expVal[0]));
          void'(expKind.pop_front()); void'(expVal.pop_front()); void'(expReq.pop_front());
        end
      end
      if (frameErr) begin
        if (expKind.size() == 0 || expKind[0] != 2) begin
          check(0, "R4", "unexpected frame error", 1, 0);
        end else begin
          check(1, expReq[0], "frame error seen", 1, 1);
          void'(expKind.pop_front()); void'(expVal.pop_front()); void'(expReq.pop_front());
        end
      end
    end
  end

  task automatic hold(input logic lv, input int n);
    lineIn = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBody(input int p, input logic [4:0] a, input logic [7:0] d,
                          input int wlo, input int whi, input bit glitch);
    logic [12:0] bits;
    bits = {a, d};
    hold(0, wlo);
    hold(1, whi);
    hold(0, p);
    hold(1, p);
    hold(0, p);
    for (int i = 12; i >= 0; i--) begin
      if (glitch && bits[i]) begin
        hold(1, p / 4);
        hold(0, 1);
        hold(1, p - p / 4 - 1);
      end else begin
        hold(bits[i], p);
      end
    end
  endtask

  task automatic expectNone(input string req);
    check(expKind.size() == 0, req, "pending expected events", expKind.size(), 0);
    check(busy == 1'b0, "R10", "busy after frame end", busy, 0);
  endtask

  task automatic doWrite(input int p, input logic [4:0] a, input logic [7:0] d,
                         input int wlo, input int whi, input bit glitch, input string req);
    expKind.push_back(1); expVal.push_back({a, d}); expReq.push_back(req);
    sendBody(p, a, d, wlo, whi, glitch);
    check(busy == 1'b1, "R10", "busy during frame", busy, 1);
    hold(1, 5 * p);
    allowWrite = 1;
    hold(1, p + 20);
    allowWrite = 0;
    expectNone(req);
  endtask

  task automatic badPeriod(input int p, input string req);
    expKind.push_back(2); expVal.push_back('0); expReq.push_back(req);
    hold(0, p); hold(1, p); hold(0, p); hold(1, p);
    hold(0, p);
    hold(1, 8 * p);
    expectNone(req);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(wrStrobe == 0 && frameErr == 0 && busy == 0, "R1", "control outputs in reset",
          {wrStrobe, frameErr, busy}, 0);
    check(wrAddr == 0 && wrData == 0, "R1", "addr/data in reset", {wrAddr, wrData}, 0);
    rstN = 1'b1;
    hold(1, 20);
    check(busy == 0, "R1", "idle after reset", busy, 0);

    // R2 writes at boundary and mid periods (R4 boundary accepted)
    doWrite(MINP, 5'h13, 8'hA5, MINP, MINP, 0, "R2");
    hold(1, 30);
    doWrite(MAXP, 5'h0C, 8'h3C, MAXP, MAXP, 0, "R4");
    hold(1, 30);
    doWrite(33, 5'h1F, 8'h00, 33, 33, 0, "R2");
    hold(1, 30);
    doWrite(25, 5'h00, 8'hFF, 25, 25, 0, "R2");
    hold(1, 30);

    // R3 wake pair durations ignored
    doWrite(40, 5'h0A, 8'h5A, 95, 130, 0, "R3");
    hold(1, 30);

    // R4 out-of-range periods
    badPeriod(MINP - 1, "R4");
    hold(1, 30);
    badPeriod(MAXP + 1, "R4");
    hold(1, 30);

    // R5 start bit high at its mid-point
    expKind.push_back(2); expVal.push_back('0); expReq.push_back("R5");
    hold(0, 30); hold(1, 30); hold(0, 30); hold(1, 30);
    hold(0, 3);
    hold(1, 240);
    expectNone("R5");

    // R7 broken standby: write dropped, outputs keep last value
    doWrite(30, 5'h11, 8'h81, 30, 30, 0, "R7");
    hold(1, 30);
    sendBody(30, 5'h06, 8'h66, 30, 30, 0);
    hold(1, 90);
    hold(0, 60);
    hold(1, 300);
    expectNone("R7");
    check({wrAddr, wrData} == {5'h11, 8'h81}, "R7", "outputs after dropped write",
          int'({wrAddr, wrData}), int'({5'h11, 8'h81}));

    // R8 oscillator not ready for a whole frame
    oscReady = 1'b0;
    hold(1, 5);
    sendBody(30, 5'h15, 8'h77, 30, 30, 0);
    check(busy == 0, "R8", "busy with oscReady low", busy, 0);
    hold(1, 300);
    expectNone("R8");
    oscReady = 1'b1;
    hold(1, 30);

    // R8 oscillator lost mid frame
    lineIn = 1'b0;
    hold(0, 30); hold(1, 30); hold(0, 30); hold(1, 30); hold(0, 30);
    hold(1, 45);
    oscReady = 1'b0;
    hold(0, 30); hold(1, 60); hold(0, 30);
    check(busy == 0, "R8", "busy after oscReady dropped", busy, 0);
    hold(1, 300);
    oscReady = 1'b1;
    hold(1, 30);
    expectNone("R8");
    check({wrAddr, wrData} == {5'h11, 8'h81}, "R8", "outputs unchanged",
          int'({wrAddr, wrData}), int'({5'h11, 8'h81}));

    // R9 glitch while idle
    hold(0, 1);
    hold(1, 30);
    check(busy == 0, "R9", "idle glitch started a frame", busy, 0);
    expectNone("R9");

    // R9 glitches inside ones bits
    doWrite(36, 5'h1B, 8'hED, 36, 36, 1, "R9");
    hold(1, 30);

    // R2 final write after all of the above
    doWrite(MINP, 5'h01, 8'h80, MINP, MINP, 0, "R2");
    hold(1, 30);

    finishRun();
  end

endmodule